// File: doc/BRIEF.md
# Re-timer PHY-Ready Hop Counter

This block sits in a link re-timer between the upstream receiver and the downstream transmitter of the low-speed sideband messages exchanged while the link trains. Each PHY-ready message arrives as an 8-bit word with a one-cycle strobe. If both of the re-timer's ports are ready, the block accepts the word and passes it downstream exactly one clock later, also with a one-cycle strobe. In two-lane operation, while the host is not addressing re-timers, the block adds one to a 3-bit hop field inside the word. The endpoints can then read how many re-timers lie on the path.

In the same case the block keeps the hop field as it arrived, before the increment, as its own address for later addressing. It also shows on a flag whether the most recent accepted word asked for addressing mode. In addressing mode, and in single-lane operation, words pass through unchanged. The serial modulation of the sideband lies outside this block.

Top module: `rtPhyReadyFwd`

## Requirements
- R1: After reset, txValid is 0, txMsg is 0x00, myIndex is 0 and addrMode is 0.
- R2: A word is accepted when rxValid and portsReady are both 1 at a clock edge. The forwarded word appears on txMsg, with txValid high for exactly one cycle, in the cycle after that edge.
- R3: When rxValid is 1 and portsReady is 0, the word is dropped. No txValid pulse follows, and myIndex and addrMode keep their values.
- R4: The hop field is msg[4:2], read as an unsigned number with msg[2] (the first bit sent) as its least significant bit. When twoLane is 1 and msg[7] is 0, the forwarded field is the received field plus one.
- R5: A received hop field of 7 is forwarded as 7. The count saturates and does not wrap.
- R6: When msg[7] is 1 (the addressing request), the accepted word is forwarded unchanged and myIndex keeps its value.
- R7: When twoLane is 0, the accepted word is forwarded unchanged and myIndex keeps its value.
- R8: When twoLane is 1 and msg[7] is 0, myIndex takes the received hop field before the increment.
- R9: Bits 7, 6 (the orientation bit), 5, 1 and 0 are always forwarded unchanged.
- R10: addrMode equals bit 7 of the most recently accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxMsg | input | 8 | Received PHY-ready word |
| rxValid | input | 1 | One-cycle strobe qualifying rxMsg |
| portsReady | input | 1 | Both re-timer ports are ready to forward |
| twoLane | input | 1 | Link runs on two lanes |
| txMsg | output | 8 | Forwarded word |
| txValid | output | 1 | One-cycle strobe qualifying txMsg |
| myIndex | output | 3 | Re-timer address captured from the hop field |
| addrMode | output | 1 | Last accepted word requested addressing |

## Verification
Every result is due one clock after the edge that accepts a word: txMsg, txValid, myIndex and addrMode all change at that single register stage. The bench drives a word on a falling edge and lets one rising edge pass. It checks all four outputs on the next falling edge. One cycle later it checks again to confirm that txValid has dropped. Dropped words and pass-through cases are checked in the same window, so a wrong pulse or a wrong index cannot slip through.

// File: rtl/rtFwdPkg.sv
package rtFwdPkg;
  localparam int MSG_W    = 8;
  localparam int HOP_LO   = 2;
  localparam int HOP_W    = 3;
  localparam int ADDR_BIT = 7;
  localparam int HOP_HI   = HOP_LO + HOP_W - 1;
  localparam logic [HOP_W-1:0] HOP_MAX = '1;

  typedef struct packed {
    logic load;     // accept and forward the word
    logic bump;     // increment the hop field
    logic capture;  // store the hop field as our index
  } fwdCtrl_t;
endpackage

// File: rtl/rtFwdCtrl.sv
module rtFwdCtrl
  import rtFwdPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [MSG_W-1:0] rxMsg,
  input  logic             rxValid,
  input  logic             portsReady,
  input  logic             twoLane,
  output fwdCtrl_t         ctrl
);
  logic accept;

  always_comb begin
    accept       = rxValid && portsReady;
    ctrl.load    = accept;
    ctrl.bump    = accept && twoLane && !rxMsg[ADDR_BIT];
    ctrl.capture = ctrl.bump;
  end

  // R3
  no_fwd_unready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !portsReady) |-> !ctrl.load);

  // R7
  no_bump_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !twoLane |-> !ctrl.bump);
endmodule

// File: rtl/rtFwdData.sv
module rtFwdData
  import rtFwdPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [MSG_W-1:0] rxMsg,
  input  fwdCtrl_t         ctrl,
  output logic [MSG_W-1:0] txMsg,
  output logic             txValid,
  output logic [HOP_W-1:0] myIndex,
  output logic             addrMode
);
  logic [HOP_W-1:0] hopIn;
  logic [HOP_W-1:0] hopNext;
  logic [MSG_W-1:0] fwdWord;

  always_comb begin
    hopIn   = rxMsg[HOP_HI:HOP_LO];
    hopNext = (hopIn == HOP_MAX) ? HOP_MAX : hopIn + 1'b1;
    fwdWord = rxMsg;
    if (ctrl.bump) fwdWord[HOP_HI:HOP_LO] = hopNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txMsg    <= '0;
      txValid  <= 1'b0;
      myIndex  <= '0;
      addrMode <= 1'b0;
    end else begin
      txValid <= ctrl.load;
      if (ctrl.load) begin
        txMsg    <= fwdWord;
        addrMode <= rxMsg[ADDR_BIT];
      end
      if (ctrl.capture) myIndex <= hopIn;
    end
  end

  // R2
  tx_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(ctrl.load));

  // R9
  side_bits_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> (txMsg[MSG_W-1:HOP_HI+1] == $past(rxMsg[MSG_W-1:HOP_HI+1]))
              && (txMsg[HOP_LO-1:0] == $past(rxMsg[HOP_LO-1:0])));

  // R6
  pass_unbumped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && !ctrl.bump) |=> txMsg == $past(rxMsg));

  // R5
  hop_saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.bump && rxMsg[HOP_HI:HOP_LO] == HOP_MAX) |=> txMsg[HOP_HI:HOP_LO] == HOP_MAX);

  // R8
  index_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |=> myIndex == $past(rxMsg[HOP_HI:HOP_LO]));

  // R3
  index_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> $stable(myIndex));
endmodule

// File: rtl/rtPhyReadyFwd.sv
module rtPhyReadyFwd
  import rtFwdPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [MSG_W-1:0] rxMsg,
  input  logic             rxValid,
  input  logic             portsReady,
  input  logic             twoLane,
  output logic [MSG_W-1:0] txMsg,
  output logic             txValid,
  output logic [HOP_W-1:0] myIndex,
  output logic             addrMode
);
  fwdCtrl_t ctrl;

  rtFwdCtrl uCtrl (
    .clk(clk), .rstN(rstN), .rxMsg(rxMsg), .rxValid(rxValid),
    .portsReady(portsReady), .twoLane(twoLane), .ctrl(ctrl)
  );

  rtFwdData uData (
    .clk(clk), .rstN(rstN), .rxMsg(rxMsg), .ctrl(ctrl),
    .txMsg(txMsg), .txValid(txValid), .myIndex(myIndex), .addrMode(addrMode)
  );
endmodule

// File: tb/sim_rtPhyReadyFwd.sv
module sim_rtPhyReadyFwd;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] rxMsg = '0;
  logic       rxValid = 1'b0;
  logic       portsReady = 1'b0;
  logic       twoLane = 1'b0;
  logic [7:0] txMsg;
  logic       txValid;
  logic [2:0] myIndex;
  logic       addrMode;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  rtPhyReadyFwd u0 (
    .clk(clk), .rstN(rstN), .rxMsg(rxMsg), .rxValid(rxValid),
    .portsReady(portsReady), .twoLane(twoLane), .txMsg(txMsg),
    .txValid(txValid), .myIndex(myIndex), .addrMode(addrMode)
  );

  // {twoLane, ready, msg, expValid, expMsg, expIdx, expAddr}
  typedef struct packed {
    logic       lanes2;
    logic       rdy;
    logic [7:0] msg;
    logic       eValid;
    logic [7:0] eMsg;
    logic [2:0] eIdx;
    logic       eAddr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 8'h41, 1'b1, 8'h45, 3'd0, 1'b0}, // R4 R9 field 0->1, bit6 kept
    '{1'b1, 1'b1, 8'h08, 1'b1, 8'h0C, 3'd2, 1'b0}, // R4 R8 field 2->3
    '{1'b1, 1'b1, 8'h1D, 1'b1, 8'h1D, 3'd7, 1'b0}, // R5 saturate
    '{1'b1, 1'b1, 8'hA4, 1'b1, 8'hA4, 3'd7, 1'b1}, // R6 addressing
    '{1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 3'd7, 1'b1}, // R3 dropped
    '{1'b0, 1'b1, 8'h10, 1'b1, 8'h10, 3'd7, 1'b0}, // R7 single lane
    '{1'b1, 1'b1, 8'h70, 1'b1, 8'h74, 3'd4, 1'b0}, // R4 R8 field 4->5
    '{1'b1, 1'b1, 8'hFF, 1'b1, 8'hFF, 3'd4, 1'b1}, // R6 R10
    '{1'b1, 1'b1, 8'h63, 1'b1, 8'h67, 3'd0, 1'b0}  // R10 cleared, R9
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic l2, input logic rdy, input logic [7:0] m);
    @(negedge clk);
    twoLane = l2; portsReady = rdy; rxMsg = m; rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  initial begin : watchdog
    #400000;
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    check(txValid == 1'b0, "R1", txValid, 0);
    check(txMsg == 8'h00, "R1", txMsg, 0);
    check(myIndex == 3'd0, "R1", myIndex, 0);
    check(addrMode == 1'b0, "R1", addrMode, 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      sendWord(VECS[i].lanes2, VECS[i].rdy, VECS[i].msg);
      check(txValid == VECS[i].eValid, "R2/R3 valid", txValid, VECS[i].eValid);
      if (VECS[i].eValid)
        check(txMsg == VECS[i].eMsg, "R4-R9 word", txMsg, VECS[i].eMsg);
      check(myIndex == VECS[i].eIdx, "R8 index", myIndex, VECS[i].eIdx);
      check(addrMode == VECS[i].eAddr, "R10 addrMode", addrMode, VECS[i].eAddr);
      @(negedge clk);
      check(txValid == 1'b0, "R2 one-cycle pulse", txValid, 0);
    end

    // R3 dropped word must leave txMsg untouched
    sendWord(1'b1, 1'b0, 8'h0C);
    check(txValid == 1'b0, "R3", txValid, 0);
    check(txMsg == 8'h67, "R3 txMsg held", txMsg, 8'h67);

    // R2 back-to-back words, each forwarded one cycle later
    @(negedge clk);
    twoLane = 1'b1; portsReady = 1'b1; rxMsg = 8'h00; rxValid = 1'b1;
    @(negedge clk);
    check(txValid == 1'b1 && txMsg == 8'h04, "R2 first", txMsg, 8'h04);
    rxMsg = 8'h18;
    @(negedge clk);
    rxValid = 1'b0;
    check(txValid == 1'b1 && txMsg == 8'h1C, "R2 second", txMsg, 8'h1C);
    check(myIndex == 3'd6, "R8 second", myIndex, 6);

    // R1 reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    check(txMsg == 8'h00 && myIndex == 3'd0, "R1 rerun", txMsg, 0);
    rstN = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule